// File: doc/BRIEF.md
# Time-Slot Data-Link Receive Tap

This block extracts a low-rate serial channel from a framed T1 or E1 receive bit stream. An upstream framer presents one bit per valid cycle together with its slot number, its bit position inside the slot, a marker for the T1 framing bit, and strobes for frame and multiframe starts. The tap chooses which bits belong to the channel: one time slot, a mask of bit positions inside that slot, and a frame filter that keeps all frames, only even frames or only odd frames. The chosen bits are packed MSB first into bytes.

Each completed byte lands in a 64-entry receive buffer. Software or a downstream HDLC engine reads it through a show-ahead byte port with a level count. The buffer runs in one of two modes. As a FIFO, it drops new bytes when it is full and raises a sticky overflow flag. As a circular buffer of programmable length, it overwrites the oldest byte. Because the channel is any subset of a slot's eight bits, and can be taken from every frame or every other frame, its rate is a multiple of 4 kbit/s up to 64 kbit/s.

Top module: `dl_tap`

## Requirements
- R1: With `cfg_unch_i`=0, a data bit is captured only when `slot_i` equals `cfg_slot_i`. In T1 mode this applies for nonzero `cfg_slot_i`, and only to bits with `fbit_i`=0.
- R2: `cfg_slot_i`=0 selects different bits in the two modes. In T1 mode (`e1_mode_i`=0) it captures only bits flagged by `fbit_i`. In E1 mode it captures the bits of slot 0, and `fbit_i` is ignored.
- R3: Frame parity starts even at reset. A bit with `mf_start_i`=1 belongs to an even frame, and a bit with `frm_start_i`=1 (and no `mf_start_i`) toggles the parity. `cfg_fsel_i`: 00 keeps all frames, 01 keeps even frames only, 10 keeps odd frames only.
- R4: `cfg_fsel_i`=11 captures nothing. The level stays unchanged.
- R5: `cfg_unch_i`=1 selects every slot and the T1 framing bit. The frame filter and the bit mask still apply.
- R6: A bit at position p is captured only if `cfg_mask_i[7-p]` is 1. A T1 framing bit uses `cfg_mask_i[7]`. Captured bits are packed MSB first. On the clock edge that captures the eighth bit, the byte is written and `level_o` rises.
- R7: When `level_o`>0, `rd_data_o` shows the oldest byte. `rd_i` pops it at the clock edge. `rd_i` has no effect at level 0.
- R8: FIFO mode (`cfg_circ_i`=0): a byte written while the level is already 64 is dropped, even if a read happens in the same cycle. The drop sets `ovf_o`, and only reset clears it.
- R9: Circular mode: the length is `cfg_len_i`, and 0 or any value above 64 means 64. A write at full length overwrites the oldest byte. The level stays at the length and `rd_data_o` moves to the oldest surviving byte.
- R10: Reset clears the level, the overflow flag, the frame parity and any partial byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| e1_mode_i | input | 1 | 1 = E1 framing, 0 = T1 framing |
| bit_vld_i | input | 1 | A line bit is present this cycle |
| bit_i | input | 1 | Line bit value |
| fbit_i | input | 1 | Current bit is the T1 framing bit |
| slot_i | input | 5 | Slot number of the current bit |
| bitpos_i | input | 3 | Position of the bit inside its slot, 0 = first |
| frm_start_i | input | 1 | Current bit is the first of a frame |
| mf_start_i | input | 1 | Current bit is the first of a multiframe |
| cfg_slot_i | input | 5 | Selected slot |
| cfg_fsel_i | input | 2 | Frame filter code |
| cfg_unch_i | input | 1 | Test mode: all slots selected |
| cfg_mask_i | input | 8 | Bit-position enable mask |
| cfg_circ_i | input | 1 | 1 = circular buffer, 0 = FIFO |
| cfg_len_i | input | 7 | Circular buffer length |
| rd_i | input | 1 | Pop the oldest byte |
| rd_data_o | output | 8 | Oldest buffered byte |
| level_o | output | 7 | Number of buffered bytes |
| ovf_o | output | 1 | Sticky FIFO overflow |

## Verification
A byte completes on the clock edge that captures its eighth selected bit. `level_o` and `ovf_o` change on that same edge, and `rd_data_o` changes on that edge too when the buffer was empty or the oldest byte was overwritten. A pop takes effect on the edge where `rd_i` is high. The bench drives each bit at the falling edge and updates its reference queue just after the next rising edge. It compares level, overflow and head byte one time unit after that edge, so every result is due and checked in the cycle of its own stimulus.

// File: rtl/dl_tap_pkg.sv
package dl_tap_pkg;
  typedef enum logic [1:0] {
    FSEL_ALL  = 2'b00,
    FSEL_EVEN = 2'b01,
    FSEL_ODD  = 2'b10,
    FSEL_NONE = 2'b11
  } fsel_e;
endpackage

// File: rtl/dl_slot_gate.sv
module dl_slot_gate import dl_tap_pkg::*; #(
  parameter int unsigned SLOT_W = 5,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned POS_W = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              e1_mode_i,
  input  logic              bit_vld_i,
  input  logic              fbit_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [POS_W-1:0]  bitpos_i,
  input  logic              frm_start_i,
  input  logic              mf_start_i,
  input  logic [SLOT_W-1:0] cfg_slot_i,
  input  logic [1:0]        cfg_fsel_i,
  input  logic              cfg_unch_i,
  input  logic [BYTE_W-1:0] cfg_mask_i,
  output logic              cap_o
);
  logic              par_q, par_cur;
  logic              fs_ok, slot_ok, m_ok, t1_fbit;
  logic [BYTE_W-1:0] mask_rev;

  // position 0 travels first and maps to the mask MSB
  for (genvar i = 0; i < BYTE_W; i++) begin : g_rev
    assign mask_rev[i] = cfg_mask_i[BYTE_W-1-i];
  end

  always_comb begin
    if (mf_start_i)       par_cur = 1'b0;
    else if (frm_start_i) par_cur = ~par_q;
    else                  par_cur = par_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        par_q <= 1'b0;
    else if (bit_vld_i) par_q <= par_cur;
  end

  always_comb begin
    unique case (fsel_e'(cfg_fsel_i))
      FSEL_ALL:  fs_ok = 1'b1;
      FSEL_EVEN: fs_ok = ~par_cur;
      FSEL_ODD:  fs_ok = par_cur;
      default:   fs_ok = 1'b0;
    endcase
  end

  assign t1_fbit = ~e1_mode_i & fbit_i;

  always_comb begin
    if (cfg_unch_i)     slot_ok = 1'b1;
    else if (e1_mode_i) slot_ok = (slot_i == cfg_slot_i);
    else if (fbit_i)    slot_ok = (cfg_slot_i == '0);
    else                slot_ok = (slot_i == cfg_slot_i) && (cfg_slot_i != '0);
  end

  assign m_ok  = t1_fbit ? mask_rev[0] : mask_rev[bitpos_i];
  assign cap_o = bit_vld_i & fs_ok & slot_ok & m_ok;

  AST_MF_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_i && mf_start_i && (cfg_fsel_i == 2'b10) |-> !cap_o); // R3
endmodule

// File: rtl/dl_packer.sv
module dl_packer #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              bit_i,
  output logic              wr_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  logic [BYTE_W-2:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  assign wr_o      = cap_i && (cnt_q == CNT_W'(BYTE_W-1));
  assign wr_data_o = {sh_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (cap_i) begin
      sh_q  <= {sh_q[BYTE_W-3:0], bit_i};
      cnt_q <= wr_o ? '0 : cnt_q + 1'b1;
    end
  end

  AST_PACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/dl_rx_buf.sv
module dl_rx_buf #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              rd_i,
  input  logic              circ_i,
  input  logic [CW-1:0]     len_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [CW-1:0]     level_o,
  output logic              ovf_o
);
  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wp_q, rp_q;
  logic [CW-1:0]     level_q, eff_len, depth;
  logic              ovf_q, full, rd_ok, stored, drop_old;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p, input logic [CW-1:0] d);
    return ({1'b0, p} == d - 1'b1) ? '0 : p + 1'b1;
  endfunction

  assign eff_len  = (len_i == '0 || len_i > CW'(DEPTH)) ? CW'(DEPTH) : len_i;
  assign depth    = circ_i ? eff_len : CW'(DEPTH);
  assign full     = level_q >= depth;
  assign rd_ok    = rd_i && (level_q != '0);
  assign stored   = wr_i && (!full || circ_i);
  assign drop_old = wr_i && full && circ_i && !rd_ok;

  always_ff @(posedge clk_i) begin
    if (stored) mem_q[wp_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q    <= '0;
      rp_q    <= '0;
      level_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (stored)            wp_q <= nxt(wp_q, depth);
      if (rd_ok || drop_old) rp_q <= nxt(rp_q, depth);
      level_q <= level_q + CW'(stored) - CW'(rd_ok) - CW'(drop_old);
      if (wr_i && full && !circ_i) ovf_q <= 1'b1;
    end
  end

  assign rd_data_o = mem_q[rp_q];
  assign level_o   = level_q;
  assign ovf_o     = ovf_q;

  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= CW'(DEPTH)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && full && !circ_i && !rd_ok |=> $stable(level_q) && ovf_q); // R8
  AST_EMPTY_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && (level_q == '0) && !wr_i |=> level_q == '0); // R7
  AST_CIRC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    circ_i && $stable(len_i) && wr_i && full |=> $stable(level_q)); // R9
endmodule

// File: rtl/dl_tap.sv
module dl_tap import dl_tap_pkg::*; #(
  parameter int unsigned BUF_DEPTH = 64,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned SLOT_W    = 5,
  localparam int unsigned POS_W = $clog2(BYTE_W),
  localparam int unsigned LVL_W = $clog2(BUF_DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              e1_mode_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              fbit_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [POS_W-1:0]  bitpos_i,
  input  logic              frm_start_i,
  input  logic              mf_start_i,
  input  logic [SLOT_W-1:0] cfg_slot_i,
  input  logic [1:0]        cfg_fsel_i,
  input  logic              cfg_unch_i,
  input  logic [BYTE_W-1:0] cfg_mask_i,
  input  logic              cfg_circ_i,
  input  logic [LVL_W-1:0]  cfg_len_i,
  input  logic              rd_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              ovf_o
);
  logic              cap, wr;
  logic [BYTE_W-1:0] wr_data;

  dl_slot_gate #(.SLOT_W(SLOT_W), .BYTE_W(BYTE_W)) u_gate (
    .clk_i, .rst_ni, .e1_mode_i, .bit_vld_i, .fbit_i, .slot_i, .bitpos_i,
    .frm_start_i, .mf_start_i, .cfg_slot_i, .cfg_fsel_i, .cfg_unch_i,
    .cfg_mask_i, .cap_o(cap)
  );

  dl_packer #(.BYTE_W(BYTE_W)) u_pack (
    .clk_i, .rst_ni, .cap_i(cap), .bit_i, .wr_o(wr), .wr_data_o(wr_data)
  );

  dl_rx_buf #(.DEPTH(BUF_DEPTH), .BYTE_W(BYTE_W)) u_buf (
    .clk_i, .rst_ni, .wr_i(wr), .wr_data_i(wr_data), .rd_i,
    .circ_i(cfg_circ_i), .len_i(cfg_len_i), .rd_data_o, .level_o, .ovf_o
  );

  AST_FSEL_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_fsel_i == 2'b11) && !rd_i |=> $stable(level_o)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i && !rd_i |=> $stable(level_o)); // R6
endmodule

// File: tb/dl_tap_bench.sv
module dl_tap_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 0, rst_ni = 0;
  logic e1_mode_i = 0, bit_vld_i = 0, bit_i = 0, fbit_i = 0;
  logic [4:0] slot_i = 0;
  logic [2:0] bitpos_i = 0;
  logic frm_start_i = 0, mf_start_i = 0;
  logic [4:0] cfg_slot_i = 0;
  logic [1:0] cfg_fsel_i = 0;
  logic cfg_unch_i = 0;
  logic [7:0] cfg_mask_i = 8'hFF;
  logic cfg_circ_i = 0;
  logic [6:0] cfg_len_i = 0;
  logic rd_i = 0;
  logic [7:0] rd_data_o;
  logic [6:0] level_o;
  logic ovf_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  dl_tap u_dl_tap (
    .clk_i(clk), .rst_ni, .e1_mode_i, .bit_vld_i, .bit_i, .fbit_i, .slot_i,
    .bitpos_i, .frm_start_i, .mf_start_i, .cfg_slot_i, .cfg_fsel_i,
    .cfg_unch_i, .cfg_mask_i, .cfg_circ_i, .cfg_len_i, .rd_i,
    .rd_data_o, .level_o, .ovf_o
  );

  int checks = 0, failures = 0, fidx = 0;
  bit done = 0;
  string tag = "R10";
  logic [7:0] mq[$];
  logic [6:0] msh;
  int mcnt;
  bit movf, mpar;

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_depth();
    if (!cfg_circ_i) return DEPTH;
    if (cfg_len_i == 0 || cfg_len_i > DEPTH) return DEPTH;
    return int'(cfg_len_i);
  endfunction

  function automatic bit qual(bit fb, int slot, int pos, bit par);
    bit fs, so, mo;
    case (cfg_fsel_i)
      2'b00: fs = 1;
      2'b01: fs = !par;
      2'b10: fs = par;
      default: fs = 0;
    endcase
    if (cfg_unch_i) so = 1;
    else if (e1_mode_i) so = (slot == int'(cfg_slot_i));
    else if (fb) so = (cfg_slot_i == 0);
    else so = (slot == int'(cfg_slot_i)) && (cfg_slot_i != 0);
    mo = (fb && !e1_mode_i) ? cfg_mask_i[7] : cfg_mask_i[7-pos];
    return fs && so && mo;
  endfunction

  task automatic compare();
    chk(tag, int'(level_o), mq.size(), "level");
    chk(tag, int'(ovf_o), int'(movf), "ovf");
    if (mq.size() > 0) chk(tag, int'(rd_data_o), int'(mq[0]), "head");
  endtask

  task automatic model_edge(bit vld, bit d, bit fb, int slot, int pos, bit frm, bit mf, bit rd);
    bit cap, wr, rd_ok, full;
    logic [7:0] b;
    int dep;
    dep = eff_depth();
    full = mq.size() >= dep;
    rd_ok = rd && mq.size() > 0;
    cap = 0;
    if (vld) begin
      if (mf) mpar = 0; else if (frm) mpar = !mpar;
      cap = qual(fb, slot, pos, mpar);
    end
    wr = cap && mcnt == 7;
    b = {msh, d};
    if (cap) begin
      if (mcnt == 7) mcnt = 0;
      else begin msh = {msh[5:0], d}; mcnt++; end
    end
    if (rd_ok) void'(mq.pop_front());
    if (wr) begin
      if (!cfg_circ_i && full) movf = 1;
      else begin
        if (cfg_circ_i && full && !rd_ok) void'(mq.pop_front());
        mq.push_back(b);
      end
    end
  endtask

  task automatic step(bit vld, bit d, bit fb, int slot, int pos, bit frm, bit mf, bit rd);
    @(negedge clk);
    bit_vld_i = vld; bit_i = d; fbit_i = fb; slot_i = 5'(slot); bitpos_i = 3'(pos);
    frm_start_i = frm; mf_start_i = mf; rd_i = rd;
    @(posedge clk);
    #1;
    model_edge(vld, d, fb, slot, pos, frm, mf, rd);
    bit_vld_i = 0; rd_i = 0; frm_start_i = 0; mf_start_i = 0;
    compare();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0;
    mq.delete(); msh = 0; mcnt = 0; movf = 0; mpar = 0; fidx = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_ni = 1;
    chk("R10", int'(level_o), 0, "reset level");
    chk("R10", int'(ovf_o), 0, "reset ovf");
  endtask

  task automatic run_frames(int n, int rdpct);
    for (int f = 0; f < n; f++) begin
      bit mf = (fidx % 4 == 0);
      if (e1_mode_i) begin
        for (int s = 0; s < 32; s++)
          for (int p = 0; p < 8; p++)
            step(1, 1'($urandom), 0, s, p, s == 0 && p == 0, mf && s == 0 && p == 0,
                 ($urandom_range(0, 99) < rdpct));
      end else begin
        step(1, 1'($urandom), 1, 0, 0, 1, mf, ($urandom_range(0, 99) < rdpct));
        for (int s = 1; s <= 24; s++)
          for (int p = 0; p < 8; p++)
            step(1, 1'($urandom), 0, s, p, 0, 0, ($urandom_range(0, 99) < rdpct));
      end
      fidx++;
    end
  endtask

  task automatic cfg(bit e1, int slot, int fsel, bit unch, int mask, bit circ, int len);
    e1_mode_i = e1; cfg_slot_i = 5'(slot); cfg_fsel_i = 2'(fsel); cfg_unch_i = unch;
    cfg_mask_i = 8'(mask); cfg_circ_i = circ; cfg_len_i = 7'(len);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    tag = "R10";
    do_reset();

    tag = "R1"; cfg(1, 5, 0, 0, 8'hFF, 0, 0); do_reset();
    run_frames(2, 0);
    chk("R1", int'(level_o), 2, "one byte per frame");

    tag = "R2"; cfg(1, 0, 0, 0, 8'hFF, 0, 0); do_reset(); run_frames(2, 0);
    chk("R2", int'(level_o), 2, "E1 slot0 bytes");
    cfg(0, 0, 0, 0, 8'hFF, 0, 0); do_reset(); run_frames(16, 0);
    chk("R2", int'(level_o), 2, "T1 F-bit bytes");

    tag = "R3"; cfg(0, 7, 2, 0, 8'hF0, 0, 0); do_reset(); run_frames(8, 0);
    chk("R3", int'(level_o), 2, "odd frames nibble");
    cfg(1, 9, 1, 0, 8'hFF, 0, 0); do_reset(); run_frames(4, 0);
    chk("R3", int'(level_o), 2, "even frames");

    tag = "R4"; cfg(1, 3, 3, 0, 8'hFF, 0, 0); do_reset(); run_frames(2, 0);
    chk("R4", int'(level_o), 0, "invalid filter");
    cfg(1, 3, 3, 1, 8'hFF, 0, 0); do_reset(); run_frames(1, 0);
    chk("R4", int'(level_o), 0, "invalid filter unch");

    tag = "R6"; cfg(1, 12, 0, 0, 8'h81, 0, 0); do_reset(); run_frames(8, 0);
    chk("R6", int'(level_o), 2, "mask two bits");

    tag = "R8"; cfg(1, 0, 0, 1, 8'hFF, 0, 0); do_reset(); run_frames(3, 0);
    chk("R5", int'(level_o), DEPTH, "unch fills fifo");
    chk("R8", int'(ovf_o), 1, "overflow sticky");

    tag = "R9"; cfg(1, 0, 0, 1, 8'hFF, 1, 5); do_reset(); run_frames(2, 0);
    chk("R9", int'(level_o), 5, "circular length");
    cfg(1, 0, 0, 1, 8'hFF, 1, 0); do_reset(); run_frames(3, 5);
    chk("R9", int'(ovf_o), 0, "no ovf circular");

    tag = "R7";
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 0, 0, 1);
    cfg(1, 2, 0, 0, 8'hFF, 0, 0); do_reset();
    step(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R7", int'(level_o), 0, "read empty");

    for (int k = 0; k < 14; k++) begin
      bit e1 = 1'($urandom);
      tag = $sformatf("R%0d", 1 + (k % 9));
      cfg(e1, e1 ? $urandom_range(0, 31) : $urandom_range(0, 24),
          ($urandom_range(0, 9) == 0) ? 3 : $urandom_range(0, 2),
          ($urandom_range(0, 7) == 0), $urandom_range(0, 255),
          1'($urandom), $urandom_range(0, 127));
      do_reset();
      run_frames(3, $urandom_range(0, 30));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog R10 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule